// File: doc/BRIEF.md
# DMA Command List Walker

The walker turns one software-supplied start word into a sequence of transfer requests for a downstream transfer engine. The start word carries a request type and an address. When the type selects a pointer list, the walker reads pointer entries one after another. Each pointer entry names an array of command records, and each record is four 32-bit words.

The walker decodes every record into a request and presents it to the engine. It waits for the engine to report that the transfer has finished, then reads the next record. A flag in each command word closes an array, and a flag in each pointer entry closes the walk.

Memory is reached through a request/response read port that has one read in flight at a time. The walk ends with a one-cycle done pulse. It ends instead with a one-cycle error pulse when the start type is unsupported or a record uses a mode other than single item.

Top module: `cmd_list_walker`

## Requirements
- R1: `start_ready` is high only while the walker is idle. A start word offered while it is busy has no effect on the reads or transfers that follow.
- R2: Start word bits [31:29] give the type, and only value 1 (pointer list) starts a walk. Any other value raises `walk_err` for one cycle in the following cycle, issues no memory read, and leaves the walker idle.
- R3: The start word and each pointer entry hold a byte address shifted right by 3 in bits [28:0], so the byte address is that field shifted left by 3. Pointer entries are read at consecutive addresses 4 bytes apart, starting from the start word address.
- R4: A record is read as four words at its base +0, +4, +8 and +12. The words are, in order, command, source, destination and length. The next record in the same array starts 16 bytes later.
- R5: When command word bit 31 is set, the next read after that record's transfer completes is the next pointer entry.
- R6: When pointer entry bit 31 is set, the walk ends after its array ends. `walk_done` pulses for one cycle in the same cycle that `start_ready` returns high.
- R7: When a command word has bits [1:0] not equal to 0, the walk ends with a one-cycle `walk_err` and the walker returns to idle. No transfer is issued and the record's remaining words are not read.
- R8: A transfer carries the source, destination and length words, and the mode in bits [1:0]. It also carries the source flow index (bits [6:3]) and the destination flow index (bits [10:7]). `xfer_flags` = {bit22 force result, bit21 unblock other, bit20 block other, bit18 destination hold, bit17 source hold}.
- R9: At most one read is outstanding. A read request holds its address until it is accepted, and the next request follows only after the response.
- R10: A transfer request holds all of its fields until `xfer_ready`. No further read is issued until `xfer_done` arrives.
- R11: After reset, `start_ready` is high and `mem_req_valid`, `xfer_valid`, `walk_done` and `walk_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start word offered |
| start_word | input | 32 | Type [31:29], address>>3 [28:0] |
| start_ready | output | 1 | Walker idle, start accepted |
| mem_req_valid | output | 1 | Read request |
| mem_req_addr | output | 32 | Byte address of the read |
| mem_req_ready | input | 1 | Read request accepted |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |
| xfer_valid | output | 1 | Transfer request presented |
| xfer_ready | input | 1 | Engine takes the request |
| xfer_src | output | 32 | Source address |
| xfer_dst | output | 32 | Destination address |
| xfer_len | output | 32 | Length |
| xfer_mode | output | 2 | Transfer mode |
| xfer_src_fc | output | 4 | Source flow-control index |
| xfer_dst_fc | output | 4 | Destination flow-control index |
| xfer_flags | output | 5 | Force result, unblock, block, dst hold, src hold |
| xfer_done | input | 1 | Engine finished the last accepted transfer |
| walk_done | output | 1 | Walk completed |
| walk_err | output | 1 | Walk rejected or aborted |

## Verification
The assertions assume a well-behaved memory and engine. `mem_rsp_valid` pulses once per accepted read and never spontaneously, and `xfer_done` pulses once per accepted transfer. The bench's memory responder only answers a handshake it has itself observed, after a varying delay. Its engine model only sends `xfer_done` after a taken request. Both toggle their ready inputs in fixed patterns so that stalls land on every state.

// File: rtl/cmd_list_walker.sv
module cmd_list_walker #(
  parameter logic [2:0] PTR_LIST_TYPE = 3'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_valid,
  input  logic [31:0] start_word,
  output logic        start_ready,
  output logic        mem_req_valid,
  output logic [31:0] mem_req_addr,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        xfer_valid,
  input  logic        xfer_ready,
  output logic [31:0] xfer_src,
  output logic [31:0] xfer_dst,
  output logic [31:0] xfer_len,
  output logic [1:0]  xfer_mode,
  output logic [3:0]  xfer_src_fc,
  output logic [3:0]  xfer_dst_fc,
  output logic [4:0]  xfer_flags,
  input  logic        xfer_done,
  output logic        walk_done,
  output logic        walk_err
);
  typedef enum logic [2:0] {
    S_IDLE, S_PTR_REQ, S_PTR_WAIT, S_CMD_REQ, S_CMD_WAIT, S_ISSUE, S_WAIT_DONE
  } state_t;

  state_t      state;
  logic [31:0] ptr_addr, cmd_addr;
  logic [1:0]  word_idx;
  logic        last_ptr;
  logic [31:0] w_cmd, w_src, w_dst, w_len;
  logic        done_q, err_q;

  assign start_ready   = (state == S_IDLE);
  assign mem_req_valid = (state == S_PTR_REQ) || (state == S_CMD_REQ);
  assign mem_req_addr  = (state == S_PTR_REQ) ? ptr_addr : cmd_addr;
  assign xfer_valid    = (state == S_ISSUE);
  assign xfer_src      = w_src;
  assign xfer_dst      = w_dst;
  assign xfer_len      = w_len;
  assign xfer_mode     = w_cmd[1:0];
  assign xfer_src_fc   = w_cmd[6:3];
  assign xfer_dst_fc   = w_cmd[10:7];
  assign xfer_flags    = {w_cmd[22], w_cmd[21], w_cmd[20], w_cmd[18], w_cmd[17]};
  assign walk_done     = done_q;
  assign walk_err      = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ptr_addr <= '0;
      cmd_addr <= '0;
      word_idx <= '0;
      last_ptr <= 1'b0;
      w_cmd    <= '0;
      w_src    <= '0;
      w_dst    <= '0;
      w_len    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        S_IDLE:
          if (start_valid) begin
            if (start_word[31:29] == PTR_LIST_TYPE) begin
              ptr_addr <= {start_word[28:0], 3'b000};
              state    <= S_PTR_REQ;
            end else begin
              err_q <= 1'b1;
            end
          end
        S_PTR_REQ:
          if (mem_req_ready) state <= S_PTR_WAIT;
        S_PTR_WAIT:
          if (mem_rsp_valid) begin
            last_ptr <= mem_rsp_data[31];
            cmd_addr <= {mem_rsp_data[28:0], 3'b000};
            ptr_addr <= ptr_addr + 32'd4;
            word_idx <= '0;
            state    <= S_CMD_REQ;
          end
        S_CMD_REQ:
          if (mem_req_ready) state <= S_CMD_WAIT;
        S_CMD_WAIT:
          if (mem_rsp_valid) begin
            cmd_addr <= cmd_addr + 32'd4;
            word_idx <= word_idx + 2'd1;
            state    <= S_CMD_REQ;
            case (word_idx)
              2'd0: begin
                w_cmd <= mem_rsp_data;
                if (mem_rsp_data[1:0] != 2'd0) begin
                  err_q <= 1'b1;
                  state <= S_IDLE;
                end
              end
              2'd1: w_src <= mem_rsp_data;
              2'd2: w_dst <= mem_rsp_data;
              default: begin
                w_len <= mem_rsp_data;
                state <= S_ISSUE;
              end
            endcase
          end
        S_ISSUE:
          if (xfer_ready) state <= S_WAIT_DONE;
        S_WAIT_DONE:
          if (xfer_done) begin
            if (!w_cmd[31])     state <= S_CMD_REQ;
            else if (!last_ptr) state <= S_PTR_REQ;
            else begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> (!mem_req_valid && !xfer_valid));

  a_r2_bad_type_err: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && start_word[31:29] != PTR_LIST_TYPE) |=> (walk_err && start_ready));

  a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  a_r10_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_src) && $stable(xfer_dst)
                                     && $stable(xfer_len) && $stable(xfer_flags)));

  a_r7_single_only: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_mode == 2'd0));

  a_r6_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_done && walk_err));
endmodule

// File: tb/cmd_list_walker_tb.sv
module cmd_list_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic start_valid = 0;
  logic [31:0] start_word = '0;
  logic start_ready;
  logic mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_req_addr, mem_rsp_data = '0;
  logic xfer_valid, xfer_ready = 0, xfer_done = 0;
  logic [31:0] xfer_src, xfer_dst, xfer_len;
  logic [1:0] xfer_mode;
  logic [3:0] xfer_src_fc, xfer_dst_fc;
  logic [4:0] xfer_flags;
  logic walk_done, walk_err;

  cmd_list_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_word(start_word),
    .start_ready(start_ready), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .xfer_len(xfer_len), .xfer_mode(xfer_mode), .xfer_src_fc(xfer_src_fc),
    .xfer_dst_fc(xfer_dst_fc), .xfer_flags(xfer_flags), .xfer_done(xfer_done),
    .walk_done(walk_done), .walk_err(walk_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] exp_rd [$];
  logic [110:0] exp_xf [$];
  int exp_end = 0;
  bit busy = 0, mon_on = 0;

  task automatic chk(bit ok, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic put_rec(logic [31:0] a, logic [31:0] c, logic [31:0] s, logic [31:0] d, logic [31:0] l);
    mem[a] = c; mem[a+4] = s; mem[a+8] = d; mem[a+12] = l;
  endtask

  function automatic logic [31:0] ptr_ent(bit last, logic [31:0] a);
    return {last, 2'b00, a[31:3]};
  endfunction

  task automatic model(logic [31:0] sw);
    logic [31:0] p, e, c, w0;
    if (sw[31:29] != 3'd1) begin exp_end = 2; return; end
    p = {sw[28:0], 3'b000};
    forever begin
      exp_rd.push_back(p);
      e = rd(p);
      c = {e[28:0], 3'b000};
      forever begin
        exp_rd.push_back(c);
        w0 = rd(c);
        if (w0[1:0] != 2'd0) begin exp_end = 2; return; end
        exp_rd.push_back(c+4); exp_rd.push_back(c+8); exp_rd.push_back(c+12);
        exp_xf.push_back({rd(c+4), rd(c+8), rd(c+12), w0[1:0], w0[6:3], w0[10:7],
                          w0[22], w0[21], w0[20], w0[18], w0[17]});
        c += 16;
        if (w0[31]) break;
      end
      if (e[31]) begin exp_end = 1; return; end
      p += 4;
    end
  endtask

  task automatic run(logic [31:0] sw, bit poke_busy);
    model(sw);
    @(negedge clk);
    start_valid = 1; start_word = sw;
    @(posedge clk); #1;
    busy = (sw[31:29] == 3'd1);
    @(negedge clk);
    start_valid = 0;
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      start_valid = 1; start_word = {3'd1, 29'h100};
      @(negedge clk);
      start_valid = 0;
    end
    while (exp_end != 0) @(negedge clk);
    chk(exp_rd.size() == 0, "R9 leftover reads", exp_rd.size(), 0);
    chk(exp_xf.size() == 0, "R10 leftover transfers", exp_xf.size(), 0);
  endtask

  int rcnt = 0, xcnt = 0;
  bit rpend = 0, xpend = 0;
  logic [31:0] raddr;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!mon_on) continue;
      mem_rsp_valid = 0;
      xfer_done = 0;
      if (rpend) begin
        if (rcnt == 0) begin mem_rsp_valid = 1; mem_rsp_data = rd(raddr); rpend = 0; end
        else rcnt--;
      end
      if (xpend) begin
        if (xcnt == 0) begin xfer_done = 1; xpend = 0; end
        else xcnt--;
      end
      mem_req_ready = (cyc % 3 != 0);
      if (mem_req_valid && mem_req_ready) begin
        logic [31:0] e;
        e = (exp_rd.size() > 0) ? exp_rd.pop_front() : 32'hdead_beef;
        chk(mem_req_addr == e, "R3 R4 R5 R9 read address", mem_req_addr, e);
        raddr = mem_req_addr; rpend = 1; rcnt = cyc % 3;
      end
      xfer_ready = (cyc % 2 == 0);
      if (xfer_valid && xfer_ready) begin
        logic [110:0] a, e;
        a = {xfer_src, xfer_dst, xfer_len, xfer_mode, xfer_src_fc, xfer_dst_fc, xfer_flags};
        e = (exp_xf.size() > 0) ? exp_xf.pop_front() : '1;
        chk(a == e, "R8 R10 transfer fields", a, e);
        xpend = 1; xcnt = cyc % 4;
      end
      if (walk_done || walk_err) begin
        chk((walk_done && exp_end == 1) || (walk_err && exp_end == 2),
            "R2 R6 R7 walk end", {walk_done, walk_err}, exp_end);
        exp_end = 0; busy = 0;
      end
      chk(start_ready == !busy, "R1 start_ready", start_ready, !busy);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(start_ready && !mem_req_valid && !xfer_valid && !walk_done && !walk_err,
        "R11 reset state", {start_ready, mem_req_valid, xfer_valid, walk_done, walk_err}, 5'b10000);
    @(negedge clk);
    rst_n = 1;
    mon_on = 1;

    // R2: unsupported types
    run({3'd0, 29'h40}, 0);
    run({3'd3, 29'h40}, 0);

    // single pointer, single record: R3 R4 R6
    mem[32'h1000] = ptr_ent(1, 32'h2000);
    put_rec(32'h2000, 32'h8000_0000 | (32'd5 << 3) | (32'd9 << 7) | (1 << 22), 32'hA0, 32'hB0, 32'd64);
    run({3'd1, 29'(32'h1000 >> 3)}, 0);

    // two pointers, 3 + 2 records, busy start ignored: R1 R5 R8
    mem[32'h3000] = ptr_ent(0, 32'h4000);
    mem[32'h3004] = ptr_ent(1, 32'h5008);
    put_rec(32'h4000, (32'd15 << 3) | (1 << 21) | (1 << 17), 32'h11, 32'h12, 32'd4);
    put_rec(32'h4010, (32'd15 << 7) | (1 << 20) | (1 << 18), 32'h21, 32'h22, 32'd8);
    put_rec(32'h4020, 32'h8000_0000 | 32'h0047_7ff8, 32'h31, 32'h32, 32'd12);
    put_rec(32'h5008, (32'd3 << 3), 32'h41, 32'h42, 32'd16);
    put_rec(32'h5018, 32'h8000_0000 | (1 << 22) | (1 << 17), 32'h51, 32'h52, 32'd20);
    run({3'd1, 29'(32'h3000 >> 3)}, 1);

    // R7: non-single mode in second record aborts
    mem[32'h6000] = ptr_ent(1, 32'h7000);
    put_rec(32'h7000, 32'd0, 32'h61, 32'h62, 32'd24);
    put_rec(32'h7010, 32'h8000_0002, 32'h71, 32'h72, 32'd28);
    run({3'd1, 29'(32'h6000 >> 3)}, 0);

    // after an abort a fresh walk still runs
    run({3'd1, 29'(32'h1000 >> 3)}, 0);

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule